// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block tracks one reservation for a requester that builds atomic read-modify-write sequences from a pair of operations: an exclusive load, then an exclusive store. The exclusive load records the address granule it touched and arms the reservation. The exclusive store that follows may write memory only if the reservation is still armed and covers the same granule. The block grants the write and returns status 0 when it succeeds. When it fails, it withholds the write and returns status 1. Software that sees a failure loops back to the exclusive load and tries again.

The reservation is lost when anything writes to the reserved granule before the exclusive store arrives. That includes a plain store from the same requester, which is how a lock is released, and a write from another agent, which the block sees on the snoop input. Any exclusive store, whether it succeeds or fails, also consumes the reservation. Addresses are compared at doubleword granularity: address bits below `GRAN_LSB` (default 3) are ignored. Every request receives a registered response in the following cycle.

Top module: `xmon_reservation_monitor`

## Requirements
- R1: After reset no reservation is held and `rsp_valid` is 0. An exclusive store issued first after reset fails.
- R2: An exclusive load (`req_op`=2'b01) followed by an exclusive store (`req_op`=2'b10) to the same granule, with no write to that granule in between, gives `rsp_permit`=1 and `rsp_status`=0.
- R3: A failing exclusive store gives `rsp_permit`=0 and `rsp_status`=1, so no write is granted.
- R4: An exclusive store to a granule other than the reserved one fails.
- R5: Two addresses that differ only in bits below `GRAN_LSB` (bits [2:0] by default) fall in the same granule.
- R6: A snoop write (`snp_valid`=1) to the reserved granule clears the reservation. A snoop write to any other granule leaves it intact.
- R7: A plain store (`req_op`=2'b11) always gets `rsp_permit`=1 and `rsp_status`=0. It clears the reservation when it hits the reserved granule and leaves the reservation intact otherwise.
- R8: Every exclusive store clears the reservation, whether it succeeds or fails, so a second exclusive store without a new load fails.
- R9: A new exclusive load replaces any existing reservation with its own granule.
- R10: An exclusive load issued in the cycle right after a failed exclusive store arms a fresh reservation, and a following exclusive store to that granule succeeds.
- R11: A snoop write in the same cycle as an exclusive store, to the reserved granule, makes the store fail. A snoop write in the same cycle as an exclusive load, to that load's granule, leaves no reservation.
- R12: `rsp_valid` is 1 in exactly the cycle after each non-idle request and 0 after an idle cycle (`req_op`=2'b00). An exclusive load responds with `rsp_permit`=0 and `rsp_status`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_op | input | 2 | Request: 00 idle, 01 exclusive load, 10 exclusive store, 11 plain store |
| req_addr | input | ADDR_W | Byte address of the request |
| snp_valid | input | 1 | A write by another agent is observed this cycle |
| snp_addr | input | ADDR_W | Byte address of the observed write |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_permit | output | 1 | The store of the previous cycle may write memory |
| rsp_status | output | 1 | Exclusive store result: 0 success, 1 failure |

## Verification
The response registers sit one edge behind the request. The bench drives a request on a falling edge and samples the three response outputs on the next falling edge, half a cycle after the registering edge. Changes to the reservation appear only in later responses, so every clear, replacement or retention is checked through the exclusive store issued immediately after it, which lands one cycle later. A snoop driven in the same cycle as a request is sampled with that request's response.

// File: rtl/xmon_pkg.sv
package xmon_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_LDEX = 2'b01,
        OP_STEX = 2'b10,
        OP_ST   = 2'b11
    } op_e;

    typedef struct packed {
        logic valid;
        logic permit;
        logic status;
    } rsp_t;

endpackage

// File: rtl/xmon_tag_match.sv
module xmon_tag_match #(
    parameter int TAG_W = 5
) (
    input  logic             en,
    input  logic [TAG_W-1:0] tag_a,
    input  logic [TAG_W-1:0] tag_b,
    output logic             hit
);
    logic [TAG_W-1:0] bit_eq;

    for (genvar g = 0; g < TAG_W; g++) begin : g_bit
        assign bit_eq[g] = ~(tag_a[g] ^ tag_b[g]);
    end

    assign hit = en & (&bit_eq);
endmodule

// File: rtl/xmon_decide.sv
module xmon_decide
    import xmon_pkg::*;
(
    input  op_e   op,
    input  logic  resv_valid,
    input  logic  req_hit_resv,
    input  logic  snp_hit_resv,
    input  logic  snp_hit_req,
    output logic  next_valid,
    output logic  take_tag,
    output rsp_t  rsp
);
    logic keep_valid;

    always_comb begin
        keep_valid = resv_valid & ~snp_hit_resv;
        next_valid = keep_valid;
        take_tag   = 1'b0;
        rsp        = '0;
        unique case (op)
            OP_LDEX: begin
                take_tag   = 1'b1;
                next_valid = ~snp_hit_req;
                rsp.valid  = 1'b1;
            end
            OP_STEX: begin
                next_valid = 1'b0;
                rsp.valid  = 1'b1;
                rsp.permit = keep_valid & req_hit_resv;
                rsp.status = ~(keep_valid & req_hit_resv);
            end
            OP_ST: begin
                next_valid = keep_valid & ~req_hit_resv;
                rsp.valid  = 1'b1;
                rsp.permit = 1'b1;
            end
            default: begin
                next_valid = keep_valid;
            end
        endcase
    end
endmodule

// File: rtl/xmon_reservation_monitor.sv
module xmon_reservation_monitor
    import xmon_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              rsp_valid,
    output logic              rsp_permit,
    output logic              rsp_status
);
    localparam int TAG_W = ADDR_W - GRAN_LSB;

    typedef struct packed {
        logic             resv_valid;
        logic [TAG_W-1:0] resv_tag;
        rsp_t             rsp;
    } state_t;

    state_t state_d, state_q;

    op_e              op;
    logic [TAG_W-1:0] req_tag, snp_tag;
    logic             req_hit_resv, snp_hit_resv, snp_hit_req;
    logic             next_valid, take_tag;
    rsp_t             rsp_next;

    assign op      = op_e'(req_op);
    assign req_tag = req_addr[ADDR_W-1:GRAN_LSB];
    assign snp_tag = snp_addr[ADDR_W-1:GRAN_LSB];

    xmon_tag_match #(.TAG_W(TAG_W)) u_req_cmp (
        .en(state_q.resv_valid), .tag_a(req_tag), .tag_b(state_q.resv_tag), .hit(req_hit_resv)
    );
    xmon_tag_match #(.TAG_W(TAG_W)) u_snp_cmp (
        .en(snp_valid & state_q.resv_valid), .tag_a(snp_tag), .tag_b(state_q.resv_tag),
        .hit(snp_hit_resv)
    );
    xmon_tag_match #(.TAG_W(TAG_W)) u_snp_req_cmp (
        .en(snp_valid), .tag_a(snp_tag), .tag_b(req_tag), .hit(snp_hit_req)
    );

    xmon_decide u_decide (
        .op(op), .resv_valid(state_q.resv_valid), .req_hit_resv(req_hit_resv),
        .snp_hit_resv(snp_hit_resv), .snp_hit_req(snp_hit_req),
        .next_valid(next_valid), .take_tag(take_tag), .rsp(rsp_next)
    );

    always_comb begin
        state_d            = state_q;
        state_d.resv_valid = next_valid;
        state_d.rsp        = rsp_next;
        if (take_tag) begin
            state_d.resv_tag = req_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid  = state_q.rsp.valid;
    assign rsp_permit = state_q.rsp.permit;
    assign rsp_status = state_q.rsp.status;

    // R3: a failed exclusive store never grants the write
    p_fail_blocks_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status) |-> !rsp_permit);

    // R8: any exclusive store leaves no reservation behind
    p_stex_consumes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEX) |=> !state_q.resv_valid);

    // R2: a granted exclusive store needed an armed reservation
    p_success_needs_resv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEX && !state_q.resv_valid) |=> (rsp_status && !rsp_permit));

    // R6: a snoop hit on the reservation drops it unless a new load re-arms
    p_snoop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit_resv && op != OP_LDEX) |=> !state_q.resv_valid);

    // R12: a response appears only after a non-idle request
    p_rsp_follows_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE) |=> !rsp_valid);

    // R7: a plain store is always granted with status 0
    p_plain_store_granted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ST) |=> (rsp_valid && rsp_permit && !rsp_status));

endmodule

// File: tb/sim_xmon_reservation_monitor.sv
module sim_xmon_reservation_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int GL = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic          snp_valid = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic          rsp_valid, rsp_permit, rsp_status;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xmon_reservation_monitor #(.ADDR_W(AW), .GRAN_LSB(GL)) u0 (
        .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr),
        .snp_valid(snp_valid), .snp_addr(snp_addr),
        .rsp_valid(rsp_valid), .rsp_permit(rsp_permit), .rsp_status(rsp_status)
    );

    localparam logic [1:0] IDLE = 2'b00, LDEX = 2'b01, STEX = 2'b10, ST = 2'b11;

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {valid,permit,status} actual %b expected %b", req, got, exp);
        end
    endtask

    // drive at falling edge, sample response at the next falling edge
    task automatic op(input logic [1:0] k, input logic [AW-1:0] a,
                      input logic sv, input logic [AW-1:0] sa, output logic [2:0] r);
        req_op = k; req_addr = a; snp_valid = sv; snp_addr = sa;
        @(negedge clk);
        req_op = IDLE; snp_valid = 1'b0;
        r = {rsp_valid, rsp_permit, rsp_status};
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [2:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", {rsp_valid, rsp_permit, rsp_status}, 3'b000);
        op(STEX, 8'h10, 0, 0, r); check("R1 stex after reset", r, 3'b101);
        op(IDLE, 0, 0, 0, r);     check("R12 idle", r, 3'b000);

        // R2 R4 R5: sweep reserved granule against every store address
        for (int a = 0; a < 256; a += 37) begin
            for (int b = 0; b < 256; b++) begin
                logic same;
                same = ((a >> GL) == (b >> GL));
                op(LDEX, a[AW-1:0], 0, 0, r);
                if (a == 0 && b == 0) check("R12 ldex rsp", r, 3'b100);
                op(STEX, b[AW-1:0], 0, 0, r);
                check(same ? "R2 R5 match" : "R4 mismatch", r, same ? 3'b110 : 3'b101);
            end
        end

        // R6: snoop to every address between load and store
        for (int c = 0; c < 256; c++) begin
            logic same;
            same = ((c >> GL) == (8'h5A >> GL));
            op(LDEX, 8'h5A, 0, 0, r);
            op(IDLE, 0, 1, c[AW-1:0], r);
            op(STEX, 8'h5D, 0, 0, r);
            check("R6 snoop", r, same ? 3'b101 : 3'b110);
        end

        // R7: plain store to every address between load and store
        for (int c = 0; c < 256; c++) begin
            logic same;
            same = ((c >> GL) == (8'hC3 >> GL));
            op(LDEX, 8'hC3, 0, 0, r);
            op(ST, c[AW-1:0], 0, 0, r);
            check("R7 plain store rsp", r, 3'b110);
            op(STEX, 8'hC0, 0, 0, r);
            check("R7 plain store clear", r, same ? 3'b101 : 3'b110);
        end

        // R8: second exclusive store without a new load
        op(LDEX, 8'h20, 0, 0, r);
        op(STEX, 8'h20, 0, 0, r); check("R8 first", r, 3'b110);
        op(STEX, 8'h20, 0, 0, r); check("R8 second", r, 3'b101);
        op(LDEX, 8'h20, 0, 0, r);
        op(STEX, 8'h48, 0, 0, r); check("R8 failed first", r, 3'b101);
        op(STEX, 8'h20, 0, 0, r); check("R8 after fail", r, 3'b101);

        // R9: replacement
        op(LDEX, 8'h30, 0, 0, r);
        op(LDEX, 8'h70, 0, 0, r);
        op(STEX, 8'h30, 0, 0, r); check("R9 old granule", r, 3'b101);
        op(LDEX, 8'h30, 0, 0, r);
        op(LDEX, 8'h70, 0, 0, r);
        op(STEX, 8'h77, 0, 0, r); check("R9 new granule", r, 3'b110);

        // R10: retry right after failure
        op(LDEX, 8'h88, 0, 0, r);
        op(IDLE, 0, 1, 8'h8F, r);
        op(STEX, 8'h88, 0, 0, r); check("R10 lost", r, 3'b101);
        op(LDEX, 8'h88, 0, 0, r);
        op(STEX, 8'h88, 0, 0, r); check("R10 retry", r, 3'b110);

        // R11: same-cycle snoop
        op(LDEX, 8'h40, 0, 0, r);
        op(STEX, 8'h40, 1, 8'h44, r); check("R11 snoop with stex", r, 3'b101);
        op(LDEX, 8'h40, 0, 0, r);
        op(STEX, 8'h40, 1, 8'h90, r); check("R11 other snoop with stex", r, 3'b110);
        op(LDEX, 8'h40, 1, 8'h47, r); check("R11 ldex rsp", r, 3'b100);
        op(STEX, 8'h40, 0, 0, r); check("R11 snoop with ldex", r, 3'b101);

        // R1: reset drops a held reservation
        op(LDEX, 8'hE0, 0, 0, r);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset rsp", {rsp_valid, rsp_permit, rsp_status}, 3'b000);
        op(STEX, 8'hE0, 0, 0, r); check("R1 reservation cleared", r, 3'b101);

        finish_up();
    end
endmodule